// File: doc/BRIEF.md
# T1 Line Alarm Detector

The block watches the received T1 bit stream and derives the line alarm conditions: a run of eight zeros, a run of sixteen zeros, carrier loss and the moment it ends, and a remote (yellow) alarm. The yellow alarm can be detected in any one of three formats. A superframe channel-bit-2 format counts channels whose bit 2 is zero. A superframe S-bit format follows the S-bit of frame 12. An extended-superframe format looks for a repeating flag in the data link bits. Frame timing comes from an upstream framer as single-cycle strobes that qualify the current bit.

Each condition sets a latched status bit. A status bit holds until software reads it. A read clears the bit only if the read is not a burst read and the condition behind the bit has gone away. A mask vector selects the status bits that pull the active-low interrupt.

Top module: `t1_alarm_det`

## Requirements
- R1: Status bit 0 sets once eight consecutive zero bits have been received with `bit_vld_i` high, and not after seven. A one bit restarts the run. Cycles with `bit_vld_i` low are ignored whatever `bit_i` holds.
- R2: Status bit 1 sets after sixteen consecutive valid zero bits, and not after fifteen.
- R3: Status bit 2 (carrier loss) sets after 192 consecutive valid zero bits, and not after 191.
- R4: Carrier loss ends when the 112 most recent valid bits hold at least 14 ones. Ones older than 112 bits do not count. When carrier loss ends, status bit 3 latches.
- R5: Yellow mode channel-bit-2 (`esf_mode_i`=0, `ylw_sbit_i`=0): yellow is declared when 256 consecutive bits strobed by `b2_stb_i` are zero, and not after 255. The first strobed one clears it. Status bit 4 reflects yellow.
- R6: Yellow mode S-bit (`esf_mode_i`=0, `ylw_sbit_i`=1): the bit strobed by `s12_stb_i` sets yellow when it is 1 and clears yellow when it is 0. Unstrobed bits have no effect.
- R7: Yellow mode data link (`esf_mode_i`=1): yellow is declared after sixteen back-to-back repetitions, without error, of the 16-bit flag on `fdl_stb_i` bits. In time order the flag is eight zeros followed by eight ones. Fifteen repetitions are not enough. Any bit that departs from the flag clears yellow.
- R8: Any change of the selected yellow mode resets the yellow detector's counts and state.
- R9: Status bits reset to 0 and hold until read. A read (`rd_i` high, `rd_burst_i` low) clears each bit whose condition is inactive. A burst read leaves all bits unchanged. A bit whose condition is still active survives a read.
- R10: `irq_no` is low exactly when some status bit is set and its `mask_i` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received data bit |
| bit_vld_i | input | 1 | `bit_i` carries a valid line bit this cycle |
| b2_stb_i | input | 1 | Current bit is bit 2 of a channel |
| s12_stb_i | input | 1 | Current bit is the frame-12 S-bit |
| fdl_stb_i | input | 1 | Current bit is a data link bit |
| esf_mode_i | input | 1 | 1 selects extended-superframe yellow format |
| ylw_sbit_i | input | 1 | In superframe, 1 selects S-bit yellow format |
| rd_i | input | 1 | Status read strobe |
| rd_burst_i | input | 1 | Qualifies `rd_i` as a burst read |
| mask_i | input | 5 | Interrupt enable per status bit |
| status_o | output | 5 | Latched status: 0 eight zeros, 1 sixteen zeros, 2 carrier loss, 3 carrier loss ended, 4 yellow |
| irq_no | output | 1 | Interrupt, active low |

## Verification
A status read can land in the same cycle as the condition that sets the bit being read. Set must win, so a read never hides a live alarm. The bench provokes this by reading while a zero run, carrier loss or S-bit yellow is still active, and expects the bit to read back set. It then removes the condition, reads again and expects the bit cleared. A burst read issued while bits are latched must leave every bit untouched.

// File: rtl/t1_alarm_pkg.sv
package t1_alarm_pkg;
  typedef enum logic [1:0] {
    YM_BIT2 = 2'd0,
    YM_SBIT = 2'd1,
    YM_FDL  = 2'd2
  } ylw_mode_e;

  localparam int unsigned ST_Z8  = 0;
  localparam int unsigned ST_Z16 = 1;
  localparam int unsigned ST_CL  = 2;
  localparam int unsigned ST_CLC = 3;
  localparam int unsigned ST_YEL = 4;
  localparam int unsigned ST_N   = 5;
endpackage

// File: rtl/t1_zero_mon.sv
module t1_zero_mon #(
  parameter int unsigned ZS  = 8,
  parameter int unsigned ZL  = 16,
  parameter int unsigned CLS = 192,
  parameter int unsigned WIN = 112,
  parameter int unsigned CLO = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_vld_i,
  output logic z8_o,
  output logic z16_o,
  output logic cl_o,
  output logic cl_clr_o
);
  localparam int unsigned RUN_W = $clog2(CLS + 1);
  localparam int unsigned CNT_W = $clog2(WIN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(CLS);
  localparam logic [CNT_W-1:0] ONES_CLR = CNT_W'(CLO);

  logic [RUN_W-1:0] run_q;
  logic [WIN-1:0]   win_q;
  logic [CNT_W-1:0] ones_q;
  logic             cl_q, cl_clr_q;
  logic             cl_end;

  assign cl_end = cl_q && (ones_q >= ONES_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      win_q  <= '0;
      ones_q <= '0;
    end else if (bit_vld_i) begin
      if (bit_i)                run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      win_q  <= {win_q[WIN-2:0], bit_i};
      ones_q <= ones_q + CNT_W'(bit_i) - CNT_W'(win_q[WIN-1]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl_q     <= 1'b0;
      cl_clr_q <= 1'b0;
    end else begin
      cl_clr_q <= cl_end;
      if (!cl_q && run_q == RUN_MAX) cl_q <= 1'b1;
      else if (cl_end)               cl_q <= 1'b0;
    end
  end

  assign z8_o     = run_q >= RUN_W'(ZS);
  assign z16_o    = run_q >= RUN_W'(ZL);
  assign cl_o     = cl_q;
  assign cl_clr_o = cl_clr_q;
endmodule

// File: rtl/t1_yellow_det.sv
module t1_yellow_det
  import t1_alarm_pkg::*;
#(
  parameter int unsigned Y_CHANNELS = 256,
  parameter int unsigned FDL_HALF   = 8,
  parameter int unsigned FDL_REPS   = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bit_i,
  input  logic      bit_vld_i,
  input  logic      b2_stb_i,
  input  logic      s12_stb_i,
  input  logic      fdl_stb_i,
  input  ylw_mode_e mode_i,
  output logic      yel_o
);
  localparam int unsigned FDL_LEN = 2 * FDL_HALF;
  localparam int unsigned PH_W    = $clog2(FDL_LEN);
  localparam int unsigned B2_W    = $clog2(Y_CHANNELS + 1);
  localparam int unsigned RP_W    = $clog2(FDL_REPS + 1);
  localparam logic [B2_W-1:0]    B2_MAX  = B2_W'(Y_CHANNELS);
  localparam logic [RP_W-1:0]    RP_MAX  = RP_W'(FDL_REPS);
  localparam logic [PH_W-1:0]    PH_LAST = PH_W'(FDL_LEN - 1);
  localparam logic [PH_W-1:0]    PH_HALF = PH_W'(FDL_HALF);
  localparam logic [FDL_LEN-1:0] FLAG    = {{FDL_HALF{1'b0}}, {FDL_HALF{1'b1}}};

  ylw_mode_e          mode_q;
  logic [B2_W-1:0]    b2_cnt_q;
  logic [FDL_LEN-2:0] hist_q;
  logic [PH_W-1:0]    phase_q;
  logic [RP_W-1:0]    reps_q;
  logic               yel_q;
  logic               exp_bit;

  assign exp_bit = phase_q >= PH_HALF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= YM_BIT2;
      b2_cnt_q <= '0;
      hist_q   <= '0;
      phase_q  <= '0;
      reps_q   <= '0;
      yel_q    <= 1'b0;
    end else if (mode_i != mode_q) begin
      mode_q   <= mode_i;
      b2_cnt_q <= '0;
      hist_q   <= '0;
      phase_q  <= '0;
      reps_q   <= '0;
      yel_q    <= 1'b0;
    end else if (bit_vld_i) begin
      unique case (mode_q)
        YM_BIT2: if (b2_stb_i) begin
          if (bit_i) begin
            b2_cnt_q <= '0;
            yel_q    <= 1'b0;
          end else if (b2_cnt_q != B2_MAX) begin
            b2_cnt_q <= b2_cnt_q + 1'b1;
            if (b2_cnt_q == B2_MAX - 1'b1) yel_q <= 1'b1;
          end
        end
        YM_SBIT: if (s12_stb_i) yel_q <= bit_i;
        YM_FDL: if (fdl_stb_i) begin
          hist_q <= {hist_q[FDL_LEN-3:0], bit_i};
          if (reps_q == '0) begin
            // acquire: first full flag seen in the sliding history
            if ({hist_q, bit_i} == FLAG) begin
              reps_q  <= RP_W'(1);
              phase_q <= '0;
              yel_q   <= (FDL_REPS == 1);
            end
          end else if (bit_i != exp_bit) begin
            reps_q  <= '0;
            phase_q <= '0;
            yel_q   <= 1'b0;
          end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
            if (reps_q != RP_MAX) reps_q <= reps_q + 1'b1;
            if (reps_q == RP_MAX - 1'b1) yel_q <= 1'b1;
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign yel_o = yel_q;
endmodule

// File: rtl/t1_status_latch.sv
module t1_status_latch #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         rd_i,
  input  logic         rd_burst_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] status_o,
  output logic         irq_no
);
  logic clr;
  assign clr = rd_i && !rd_burst_i;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= 1'b0;
      else         st_q <= src_i[i] | (st_q & ~clr); // set wins over read
    end
    assign status_o[i] = st_q;
  end

  assign irq_no = ~|(status_o & mask_i);
endmodule

// File: rtl/t1_alarm_det.sv
module t1_alarm_det
  import t1_alarm_pkg::*;
#(
  parameter int unsigned ZERO_SHORT  = 8,
  parameter int unsigned ZERO_LONG   = 16,
  parameter int unsigned CL_SET_ZERO = 192,
  parameter int unsigned CL_WIN      = 112,
  parameter int unsigned CL_CLR_ONES = 14,
  parameter int unsigned Y_CHANNELS  = 256,
  parameter int unsigned FDL_HALF    = 8,
  parameter int unsigned FDL_REPS    = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_i,
  input  logic            bit_vld_i,
  input  logic            b2_stb_i,
  input  logic            s12_stb_i,
  input  logic            fdl_stb_i,
  input  logic            esf_mode_i,
  input  logic            ylw_sbit_i,
  input  logic            rd_i,
  input  logic            rd_burst_i,
  input  logic [ST_N-1:0] mask_i,
  output logic [ST_N-1:0] status_o,
  output logic            irq_no
);
  logic      z8, z16, cl, cl_clr, yel;
  ylw_mode_e ymode;
  logic [ST_N-1:0] src;

  assign ymode = esf_mode_i ? YM_FDL : (ylw_sbit_i ? YM_SBIT : YM_BIT2);

  t1_zero_mon #(
    .ZS(ZERO_SHORT), .ZL(ZERO_LONG), .CLS(CL_SET_ZERO),
    .WIN(CL_WIN), .CLO(CL_CLR_ONES)
  ) u_zero (
    .clk_i, .rst_ni, .bit_i, .bit_vld_i,
    .z8_o(z8), .z16_o(z16), .cl_o(cl), .cl_clr_o(cl_clr)
  );

  t1_yellow_det #(
    .Y_CHANNELS(Y_CHANNELS), .FDL_HALF(FDL_HALF), .FDL_REPS(FDL_REPS)
  ) u_yel (
    .clk_i, .rst_ni, .bit_i, .bit_vld_i, .b2_stb_i, .s12_stb_i, .fdl_stb_i,
    .mode_i(ymode), .yel_o(yel)
  );

  always_comb begin
    src         = '0;
    src[ST_Z8]  = z8;
    src[ST_Z16] = z16;
    src[ST_CL]  = cl;
    src[ST_CLC] = cl_clr;
    src[ST_YEL] = yel;
  end

  t1_status_latch #(.N(ST_N)) u_stat (
    .clk_i, .rst_ni, .src_i(src), .rd_i, .rd_burst_i, .mask_i,
    .status_o, .irq_no
  );
endmodule

// File: rtl/t1_alarm_det_chk.sv
module t1_alarm_det_chk
  import t1_alarm_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bit_i,
  input logic            bit_vld_i,
  input logic            rd_i,
  input logic            rd_burst_i,
  input logic [ST_N-1:0] mask_i,
  input logic [ST_N-1:0] status_o,
  input logic            irq_no
);
  // R1: eight-zero flag rises only two cycles after a valid zero bit
  a_r1_z8_after_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_Z8]) |-> $past(bit_vld_i && !bit_i, 2));

  // R3: carrier loss implies a sixteen-zero run is already latched
  a_r3_cl_needs_z16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_CL]) |-> status_o[ST_Z16]);

  // R4: carrier-loss-ended status only follows a latched carrier loss
  a_r4_clc_after_cl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_CLC]) |-> $past(status_o[ST_CL]));

  // R9: without a clearing read no latched bit drops
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && !rd_burst_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R10: an active interrupt needs an enabled mask bit
  a_r10_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (|mask_i));

  // R10: empty status never interrupts
  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == '0) |-> irq_no);
endmodule

bind t1_alarm_det t1_alarm_det_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
  .rd_i(rd_i), .rd_burst_i(rd_burst_i), .mask_i(mask_i),
  .status_o(status_o), .irq_no(irq_no)
);

// File: tb/t1_alarm_det_bench.sv
`timescale 1ns/1ps
module t1_alarm_det_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0, bit_vld_i = 1'b0;
  logic       b2_stb_i = 1'b0, s12_stb_i = 1'b0, fdl_stb_i = 1'b0;
  logic       esf_mode_i = 1'b0, ylw_sbit_i = 1'b0;
  logic       rd_i = 1'b0, rd_burst_i = 1'b0;
  logic [4:0] mask_i = '0;
  logic [4:0] status_o;
  logic       irq_no;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string      req;
    logic [4:0] sel;
    logic [4:0] exp;
    bit         use_irq;
    logic       exp_irq;
  } exp_t;
  exp_t sb_q[$];
  exp_t cur;

  always #4 clk = ~clk;

  t1_alarm_det u_t1_alarm_det (
    .clk_i(clk), .rst_ni, .bit_i, .bit_vld_i, .b2_stb_i, .s12_stb_i,
    .fdl_stb_i, .esf_mode_i, .ylw_sbit_i, .rd_i, .rd_burst_i, .mask_i,
    .status_o, .irq_no
  );

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      cur = sb_q.pop_front();
      checks++;
      if (cur.use_irq) begin
        if (irq_no !== cur.exp_irq) begin
          fails++;
          $display("FAIL %s irq_no actual=%b expected=%b", cur.req, irq_no, cur.exp_irq);
        end
      end else if ((status_o & cur.sel) !== cur.exp) begin
        fails++;
        $display("FAIL %s status actual=%b expected=%b (sel %b)",
                 cur.req, status_o & cur.sel, cur.exp, cur.sel);
      end
    end
  end

  task automatic expect_st(input string req, input logic [4:0] sel, input logic [4:0] exp);
    exp_t e;
    e.req = req; e.sel = sel; e.exp = exp; e.use_irq = 1'b0; e.exp_irq = 1'b1;
    sb_q.push_back(e);
    @(posedge clk); @(posedge clk);
  endtask

  task automatic expect_irq(input string req, input logic exp);
    exp_t e;
    e.req = req; e.sel = '0; e.exp = '0; e.use_irq = 1'b1; e.exp_irq = exp;
    sb_q.push_back(e);
    @(posedge clk); @(posedge clk);
  endtask

  task automatic put(input logic b, input logic v, input logic s2,
                     input logic s12, input logic sf);
    @(posedge clk); #1;
    bit_i = b; bit_vld_i = v; b2_stb_i = s2; s12_stb_i = s12; fdl_stb_i = sf;
  endtask

  task automatic settle();
    @(posedge clk); #1;
    bit_vld_i = 1'b0; b2_stb_i = 1'b0; s12_stb_i = 1'b0; fdl_stb_i = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    settle();
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) put(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    settle();
  endtask

  task automatic b2_bits(input logic b, input int n);
    for (int i = 0; i < n; i++) put(b, 1'b1, 1'b1, 1'b0, 1'b0);
    settle();
  endtask

  task automatic fdl_flags(input int n);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 16; i++) put(i >= 8, 1'b1, 1'b0, 1'b0, 1'b1);
    settle();
  endtask

  task automatic do_read(input logic burst);
    @(posedge clk); #1; rd_i = 1'b1; rd_burst_i = burst;
    @(posedge clk); #1; rd_i = 1'b0; rd_burst_i = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    expect_st("R9 reset status", 5'b11111, 5'b00000);
    expect_irq("R10 reset irq", 1'b1);

    // R1: seven zeros, an invalid one, one more zero
    zeros(7);
    expect_st("R1 seven zeros", 5'b00001, 5'b00000);
    put(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    zeros(1);
    expect_st("R1 eighth zero past invalid bit", 5'b00001, 5'b00001);

    // R2
    zeros(7);
    expect_st("R2 fifteen zeros", 5'b00010, 5'b00000);
    zeros(1);
    expect_st("R2 sixteen zeros", 5'b00010, 5'b00010);

    // R9: read while run still active keeps bits
    do_read(1'b0);
    expect_st("R9 active survives read", 5'b00011, 5'b00011);

    // R10
    mask_i = 5'b00001;
    expect_irq("R10 masked-in bit", 1'b0);
    mask_i = 5'b10000;
    expect_irq("R10 masked-out bit", 1'b1);
    mask_i = '0;

    ones(1);
    do_read(1'b1);
    expect_st("R9 burst read keeps bits", 5'b00011, 5'b00011);
    do_read(1'b0);
    expect_st("R9 read clears inactive", 5'b00011, 5'b00000);

    // R3
    zeros(191);
    expect_st("R3 191 zeros", 5'b00100, 5'b00000);
    zeros(1);
    expect_st("R3 192 zeros", 5'b00100, 5'b00100);

    // R4
    ones(13);
    do_read(1'b0);
    expect_st("R4 thirteen ones keep loss", 5'b01100, 5'b00100);
    zeros(99);
    ones(1);
    do_read(1'b0);
    expect_st("R4 old ones leave window", 5'b01100, 5'b00100);
    ones(14);
    expect_st("R4 loss ended latched", 5'b01000, 5'b01000);
    do_read(1'b0);
    expect_st("R4 read clears both", 5'b01100, 5'b00000);

    // R5: channel bit 2 mode (reset default)
    b2_bits(1'b0, 255);
    expect_st("R5 255 channels", 5'b10000, 5'b00000);
    b2_bits(1'b0, 1);
    expect_st("R5 256 channels", 5'b10000, 5'b10000);
    b2_bits(1'b1, 1);
    do_read(1'b0);
    expect_st("R5 one clears yellow", 5'b10000, 5'b00000);

    // R8: mode change resets the channel count
    b2_bits(1'b0, 200);
    ylw_sbit_i = 1'b1; repeat (2) @(posedge clk);
    ylw_sbit_i = 1'b0; repeat (2) @(posedge clk);
    b2_bits(1'b0, 100);
    expect_st("R8 count restarted", 5'b10000, 5'b00000);
    b2_bits(1'b0, 156);
    expect_st("R8 full count after restart", 5'b10000, 5'b10000);
    b2_bits(1'b1, 1);
    do_read(1'b0);

    // R6: S-bit mode
    ylw_sbit_i = 1'b1; repeat (2) @(posedge clk);
    put(1'b1, 1'b1, 1'b0, 1'b0, 1'b0); settle();
    expect_st("R6 unstrobed one ignored", 5'b10000, 5'b00000);
    put(1'b1, 1'b1, 1'b0, 1'b1, 1'b0); settle();
    expect_st("R6 S-bit one sets", 5'b10000, 5'b10000);
    do_read(1'b0);
    expect_st("R6 active yellow survives read", 5'b10000, 5'b10000);
    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b0); settle();
    do_read(1'b0);
    expect_st("R6 S-bit zero clears", 5'b10000, 5'b00000);

    // R7: data link mode
    esf_mode_i = 1'b1; repeat (2) @(posedge clk);
    fdl_flags(15);
    expect_st("R7 fifteen flags", 5'b10000, 5'b00000);
    fdl_flags(1);
    expect_st("R7 sixteen flags", 5'b10000, 5'b10000);
    for (int i = 0; i < 12; i++) put(i >= 8, 1'b1, 1'b0, 1'b0, 1'b1);
    put(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    settle();
    do_read(1'b0);
    expect_st("R7 broken flag clears", 5'b10000, 5'b00000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule